// File: doc/BRIEF.md
# Saturating Monitor Counter Bank

This block keeps a set of event counters that measure channel activity and dead time. In normal operation each counter advances by one on every clock in which its own strobe is high. An internal interval timer marks the end of each accumulation interval (one second of the processing clock, set by a parameter). On that cycle every counter value moves into a holding register that software reads, and the counter restarts from zero. A strobe that arrives in that same cycle counts as the first event of the new interval, so no event is lost. A counter that reaches its all-ones value stays there until it is cleared or loaded.

The bank holds two counter widths: wide counters come first in index order and narrow counters follow. For production and in-flight self-test, a test mode isolates the counters from their strobes. Software can then shift a full image of preset values into a serial register and load every counter from it in one cycle. It can also step all counters together by one, any number of times, and capture all counter values into the same serial register to shift them out. This lets the full count range and the saturation point be checked with no detector activity.

Top module: `mon_counter_bank`

## Requirements
- R1: After reset every counter, every held value and the serial register are zero, and `interval_end_o` is low.
- R2: In normal mode `interval_end_o` is high for exactly one cycle in every `INTERVAL_CYCLES` cycles.
- R3: In the cycle where `interval_end_o` is high, each counter value is copied into `held_o` and the counter restarts at 1 if its strobe is high in that cycle, else at 0. `held_o` changes in no other cycle. Layout of `held_o` and of the serial register: counter 0 in the most significant field, then the others in index order, each field with its MSB on the left, wide fields `W_WIDE` bits and narrow fields `W_NARROW` bits.
- R4: In normal mode, outside the interval-end cycle, a counter increases by one in each cycle where its strobe bit is high.
- R5: A counter at its all-ones value stays at all-ones on any further increment, whether the increment comes from a strobe or from a test step.
- R6: Each cycle with `sh_en_i` high shifts the serial register one place toward its MSB, with `sh_din_i` entering at bit 0. `sh_dout_o` always shows the register MSB.
- R7: In test mode, `tst_capture_i` copies all counter values into the serial register, and it takes priority over a shift in the same cycle.
- R8: In test mode, `tst_load_i` loads every counter from its field of the serial register, and it takes priority over `tst_step_i`.
- R9: In test mode, `tst_step_i` adds one to every counter at once, in every cycle where it is high.
- R10: While `test_mode_i` is high, the strobes have no effect, `interval_end_o` stays low and the interval timer holds at zero. The first interval end after leaving test mode therefore comes `INTERVAL_CYCLES` cycles later.
- R11: Outside test mode, `tst_load_i`, `tst_step_i` and `tst_capture_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Isolates the counters from their strobes and enables the test commands |
| strobe_i | input | N_WIDE+N_NARROW | One event strobe per counter |
| tst_load_i | input | 1 | Loads all counters from the serial register (test mode) |
| tst_step_i | input | 1 | Collective increment of all counters (test mode) |
| tst_capture_i | input | 1 | Copies all counters into the serial register (test mode) |
| sh_en_i | input | 1 | Shifts the serial register by one bit |
| sh_din_i | input | 1 | Serial data into bit 0 |
| sh_dout_o | output | 1 | Serial register MSB |
| interval_end_o | output | 1 | One-cycle marker of an interval end |
| held_o | output | N_WIDE*W_WIDE+N_NARROW*W_NARROW | Counter values from the last completed interval |

## Verification
The assertions assume that the test commands matter only while `test_mode_i` is high. They also assume that a shift and a capture in the same cycle resolve to the capture, and that the strobes may take any value at any time, including during test mode and in the interval-end cycle. The stimulus exercises these freedoms on purpose. It holds every strobe high through the whole test-mode phase, keeps one strobe high across two interval ends, and pulses every test command while in normal mode. The inputs change only on falling edges, so every command stays level for one whole cycle. No saturation path needs a long run: saturation is reached by preloading values one or two steps below all-ones.

// File: rtl/mon_pkg.sv
package mon_pkg;

  // Per-cycle command applied to every counter of the bank
  typedef enum logic [2:0] {
    CO_IDLE  = 3'd0,  // hold value
    CO_COUNT = 3'd1,  // normal mode: advance on own strobe
    CO_ROLL  = 3'd2,  // interval end: move to hold, restart
    CO_LOAD  = 3'd3,  // test: take preset from serial image
    CO_STEP  = 3'd4   // test: collective increment
  } cnt_op_e;

  // Saturating increment of a w-bit value carried in 64 bits
  function automatic logic [63:0] sat_step(input logic [63:0] v, input int unsigned w);
    logic [63:0] ceiling;
    ceiling = (64'd1 << w) - 64'd1;
    return (v >= ceiling) ? ceiling : v + 64'd1;
  endfunction

  // Bit position of the LSB of counter idx in the flat image:
  // counter 0 sits at the top, wide counters before narrow ones
  function automatic int unsigned field_lsb(input int unsigned idx, input int unsigned nw,
                                            input int unsigned nn, input int unsigned ww,
                                            input int unsigned wn);
    int unsigned total;
    total = nw * ww + nn * wn;
    if (idx < nw) return total - (idx + 1) * ww;
    return total - nw * ww - (idx - nw + 1) * wn;
  endfunction

endpackage

// File: rtl/mon_interval_timer.sv
module mon_interval_timer #(
  parameter int unsigned CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] count_q;

  assign tick_o = run_i && (count_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (!run_i) count_q <= '0;
    else if (tick_o) count_q <= '0;
    else             count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/mon_sat_counter.sv
module mon_sat_counter
  import mon_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op_i,
  input  logic         strobe_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] cnt_q, hold_q, cnt_sat;

  assign cnt_sat = W'(sat_step(64'(cnt_q), W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      case (op_i)
        CO_COUNT: if (strobe_i) cnt_q <= cnt_sat;
        CO_ROLL: begin
          hold_q <= cnt_q;
          cnt_q  <= W'(strobe_i);
        end
        CO_LOAD: cnt_q <= preset_i;
        CO_STEP: cnt_q <= cnt_sat;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/mon_serial_port.sv
module mon_serial_port #(
  parameter int unsigned TW = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  logic          shift_i,
  input  logic          sdi_i,
  input  logic [TW-1:0] par_i,
  output logic [TW-1:0] par_o,
  output logic          sdo_o
);
  logic [TW-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sreg_q <= '0;
    else if (capture_i) sreg_q <= par_i;
    else if (shift_i)   sreg_q <= {sreg_q[TW-2:0], sdi_i};
  end

  assign par_o = sreg_q;
  assign sdo_o = sreg_q[TW-1];
endmodule

// File: rtl/mon_counter_bank.sv
module mon_counter_bank
  import mon_pkg::*;
#(
  parameter int unsigned N_WIDE          = 2,
  parameter int unsigned N_NARROW        = 3,
  parameter int unsigned W_WIDE          = 24,
  parameter int unsigned W_NARROW        = 16,
  parameter int unsigned INTERVAL_CYCLES = 20_000_000
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      test_mode_i,
  input  logic [N_WIDE+N_NARROW-1:0]                strobe_i,
  input  logic                                      tst_load_i,
  input  logic                                      tst_step_i,
  input  logic                                      tst_capture_i,
  input  logic                                      sh_en_i,
  input  logic                                      sh_din_i,
  output logic                                      sh_dout_o,
  output logic                                      interval_end_o,
  output logic [N_WIDE*W_WIDE+N_NARROW*W_NARROW-1:0] held_o
);
  localparam int unsigned N_CNT   = N_WIDE + N_NARROW;
  localparam int unsigned TOTAL_W = N_WIDE * W_WIDE + N_NARROW * W_NARROW;

  // Named internal events, observed by the bound checker
  logic               ivl_tick;
  logic               cap_en;
  cnt_op_e            cnt_op;
  logic [TOTAL_W-1:0] cnt_flat;
  logic [TOTAL_W-1:0] hold_flat;
  logic [TOTAL_W-1:0] shreg;

  mon_interval_timer #(.CYCLES(INTERVAL_CYCLES)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (!test_mode_i),
    .tick_o (ivl_tick)
  );

  always_comb begin
    if (!test_mode_i)    cnt_op = ivl_tick ? CO_ROLL : CO_COUNT;
    else if (tst_load_i) cnt_op = CO_LOAD;
    else if (tst_step_i) cnt_op = CO_STEP;
    else                 cnt_op = CO_IDLE;
  end

  assign cap_en = test_mode_i && tst_capture_i;

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    localparam int unsigned LSB = field_lsb(i, N_WIDE, N_NARROW, W_WIDE, W_NARROW);
    mon_sat_counter #(.W(W_WIDE)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (cnt_op),
      .strobe_i (strobe_i[i]),
      .preset_i (shreg[LSB +: W_WIDE]),
      .count_o  (cnt_flat[LSB +: W_WIDE]),
      .hold_o   (hold_flat[LSB +: W_WIDE])
    );
  end

  for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow
    localparam int unsigned LSB = field_lsb(N_WIDE + j, N_WIDE, N_NARROW, W_WIDE, W_NARROW);
    mon_sat_counter #(.W(W_NARROW)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (cnt_op),
      .strobe_i (strobe_i[N_WIDE + j]),
      .preset_i (shreg[LSB +: W_NARROW]),
      .count_o  (cnt_flat[LSB +: W_NARROW]),
      .hold_o   (hold_flat[LSB +: W_NARROW])
    );
  end

  mon_serial_port #(.TW(TOTAL_W)) i_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (cap_en),
    .shift_i   (sh_en_i),
    .sdi_i     (sh_din_i),
    .par_i     (cnt_flat),
    .par_o     (shreg),
    .sdo_o     (sh_dout_o)
  );

  assign interval_end_o = ivl_tick;
  assign held_o         = hold_flat;

  if (N_CNT == 0) begin : g_bad_cfg
    $error("counter bank needs at least one counter");
  end
endmodule

// File: rtl/mon_counter_bank_chk.sv
module mon_counter_bank_chk
  import mon_pkg::*;
#(
  parameter int unsigned N_WIDE   = 2,
  parameter int unsigned N_NARROW = 3,
  parameter int unsigned W_WIDE   = 24,
  parameter int unsigned W_NARROW = 16,
  localparam int unsigned N_CNT   = N_WIDE + N_NARROW,
  localparam int unsigned TOTAL_W = N_WIDE * W_WIDE + N_NARROW * W_NARROW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               test_mode_i,
  input logic               tst_load_i,
  input logic               tst_step_i,
  input logic               tst_capture_i,
  input logic               sh_en_i,
  input logic               sh_dout_o,
  input logic               interval_end_o,
  input logic [TOTAL_W-1:0] held_o,
  input logic [TOTAL_W-1:0] cnt_flat,
  input logic [TOTAL_W-1:0] shreg
);
  // R3
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end_o |=> held_o == $past(cnt_flat));

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end_o |=> $stable(held_o));

  // R10
  no_tick_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i |-> !interval_end_o);

  // R10
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i && !tst_load_i && !tst_step_i |=> $stable(cnt_flat));

  // R6
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en_i && !(test_mode_i && tst_capture_i) |=> sh_dout_o == $past(shreg[TOTAL_W-2]));

  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i && tst_capture_i |=> shreg == $past(cnt_flat));

  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i && tst_load_i |=> cnt_flat == $past(shreg));

  // R11
  no_capture_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_i && !sh_en_i |=> $stable(shreg));

  for (genvar i = 0; i < N_CNT; i++) begin : g_sat
    localparam int unsigned WI  = (i < N_WIDE) ? W_WIDE : W_NARROW;
    localparam int unsigned LSB = field_lsb(i, N_WIDE, N_NARROW, W_WIDE, W_NARROW);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[LSB +: WI] == {WI{1'b1}}) && !interval_end_o && !(test_mode_i && tst_load_i)
      |=> cnt_flat[LSB +: WI] == {WI{1'b1}});
  end
endmodule

bind mon_counter_bank mon_counter_bank_chk #(
  .N_WIDE   (N_WIDE),
  .N_NARROW (N_NARROW),
  .W_WIDE   (W_WIDE),
  .W_NARROW (W_NARROW)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .test_mode_i    (test_mode_i),
  .tst_load_i     (tst_load_i),
  .tst_step_i     (tst_step_i),
  .tst_capture_i  (tst_capture_i),
  .sh_en_i        (sh_en_i),
  .sh_dout_o      (sh_dout_o),
  .interval_end_o (interval_end_o),
  .held_o         (held_o),
  .cnt_flat       (cnt_flat),
  .shreg          (shreg)
);

// File: tb/test_mon_counter_bank.sv
module test_mon_counter_bank;
  localparam int NW = 2, NN = 2, WW = 24, WN = 16, IVL = 40;
  localparam int NT = NW + NN;
  localparam int TW = NW * WW + NN * WN;

  typedef longint cvec_t[NT];
  typedef bit     bitq_t[$];

  logic          clk = 0, rst_n = 0, tm = 0, ld = 0, st = 0, cap = 0, sh = 0, sdi = 0;
  logic [NT-1:0] strobe = '0;
  logic          sdo, iend;
  logic [TW-1:0] held;

  int checks = 0, fails = 0, ends_in_test = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mon_counter_bank #(
    .N_WIDE(NW), .N_NARROW(NN), .W_WIDE(WW), .W_NARROW(WN), .INTERVAL_CYCLES(IVL)
  ) i_mon_counter_bank (
    .clk(clk), .rst_n(rst_n), .test_mode_i(tm), .strobe_i(strobe),
    .tst_load_i(ld), .tst_step_i(st), .tst_capture_i(cap),
    .sh_en_i(sh), .sh_din_i(sdi), .sh_dout_o(sdo),
    .interval_end_o(iend), .held_o(held)
  );

  // ---------------- behavioural reference ----------------
  function automatic int wof(int i);
    return (i < NW) ? WW : WN;
  endfunction

  function automatic longint bump(longint v, int i);
    longint top = (longint'(1) << wof(i)) - 1;
    return (v == top) ? v : v + 1;
  endfunction

  function automatic bitq_t to_bits(cvec_t c);
    bitq_t q;
    for (int i = 0; i < NT; i++)
      for (int b = wof(i) - 1; b >= 0; b--) q.push_back(c[i][b]);
    return q;
  endfunction

  function automatic logic [TW-1:0] pack(cvec_t c);
    bitq_t q = to_bits(c);
    logic [TW-1:0] v;
    for (int k = 0; k < TW; k++) v[TW-1-k] = q[k];
    return v;
  endfunction

  function automatic longint field_of(bitq_t q, int idx);
    int off = 0;
    longint v = 0;
    for (int i = 0; i < idx; i++) off += wof(i);
    for (int b = 0; b < wof(idx); b++) v = (v << 1) | longint'(q[off + b]);
    return v;
  endfunction

  cvec_t m_cnt, m_hold;
  bitq_t m_q;
  int    m_timer;

  always @(posedge clk) begin
    cvec_t oc;
    bitq_t oq;
    bit    end_now;
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
      m_q = {};
      for (int k = 0; k < TW; k++) m_q.push_back(1'b0);
      m_timer = 0;
    end else begin
      oc = m_cnt;
      oq = m_q;
      end_now = !tm && (m_timer == IVL - 1);
      for (int i = 0; i < NT; i++) begin
        if (!tm) begin
          if (end_now) begin m_hold[i] = oc[i]; m_cnt[i] = strobe[i] ? 1 : 0; end
          else if (strobe[i]) m_cnt[i] = bump(oc[i], i);
        end else if (ld) m_cnt[i] = field_of(oq, i);
        else if (st)     m_cnt[i] = bump(oc[i], i);
      end
      m_timer = (tm || end_now) ? 0 : m_timer + 1;
      if (tm && cap) m_q = to_bits(oc);
      else if (sh) begin void'(m_q.pop_front()); m_q.push_back(sdi); end
    end
    #2;
    if (rst_n && !done) begin
      checks += 3;
      if (held !== pack(m_hold)) begin
        fails++; $display("FAIL R3 held_o act=%h exp=%h", held, pack(m_hold));
      end
      if (sdo !== m_q[0]) begin
        fails++; $display("FAIL R6 sh_dout_o act=%b exp=%b", sdo, m_q[0]);
      end
      if (iend !== (!tm && m_timer == IVL - 1)) begin
        fails++; $display("FAIL R2 interval_end_o act=%b exp=%b", iend, !tm && m_timer == IVL - 1);
      end
    end
  end

  always @(negedge clk) if (rst_n && tm && iend) ends_in_test++;

  // ---------------- helpers ----------------
  task automatic chk_vec(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic chk_int(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic xfer(input logic [TW-1:0] din, output logic [TW-1:0] dout);
    for (int k = 0; k < TW; k++) begin
      dout[TW-1-k] = sdo;
      sdi = din[TW-1-k];
      sh  = 1;
      @(negedge clk);
    end
    sh = 0; sdi = 0;
  endtask

  task automatic read_all(output logic [TW-1:0] v);
    cap = 1; @(negedge clk); cap = 0;
    xfer('0, v);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [TW-1:0] got, pat;
    cvec_t cv;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk_vec("R1 held_o after reset", held, '0);
    chk_int("R1 sh_dout_o after reset", sdo, 0);
    chk_int("R1 interval_end_o after reset", iend, 0);

    // R4 / R3: counted strobes, one strobe held across interval ends
    while (!iend) @(negedge clk);
    strobe[3] = 1;
    @(negedge clk);
    strobe[0] = 1; strobe[1] = 1;
    repeat (3) @(negedge clk);
    strobe[0] = 0;
    repeat (4) @(negedge clk);
    strobe[1] = 0;
    while (!iend) @(negedge clk);
    @(negedge clk);
    cv = '{3, 7, 0, IVL};
    chk_vec("R4 held counts after strobes", held, pack(cv));
    n = 1;
    while (!iend) begin @(negedge clk); n++; end
    chk_int("R2 interval period", n, IVL);
    @(negedge clk);
    cv = '{0, 0, 0, IVL};
    chk_vec("R3 strobe in end cycle carried", held, pack(cv));

    // Test mode with all strobes high throughout (R10)
    tm = 1; strobe = '1;
    cv = '{24'hFFFFFE, 5, 16'hFFFD, 0};
    pat = pack(cv);
    xfer(pat, got);
    xfer(pat, got);
    chk_vec("R6 serial round trip", got, pat);
    ld = 1; @(negedge clk); ld = 0;
    read_all(got);
    chk_vec("R8 load from serial image", got, pat);
    st = 1; repeat (3) @(negedge clk); st = 0;
    read_all(got);
    cv = '{24'hFFFFFF, 8, 16'hFFFF, 3};
    chk_vec("R7 captured image after steps", got, pack(cv));
    chk_int("R5 wide counter saturates", longint'(got[TW-1 -: WW]), 24'hFFFFFF);
    chk_int("R5 narrow counter saturates", longint'(got[WN +: WN]), 16'hFFFF);
    chk_int("R9 step counter 1", longint'(got[TW-WW-1 -: WW]), 8);
    chk_int("R9 step counter 3", longint'(got[WN-1:0]), 3);
    chk_int("R10 no interval end in test mode", ends_in_test, 0);

    // Back to normal mode: test commands must do nothing (R11)
    strobe = '0; tm = 0;
    n = 0;
    ld = 1;  @(negedge clk); n++; ld = 0;
    st = 1;  @(negedge clk); n++; st = 0;
    cap = 1; @(negedge clk); n++; cap = 0;
    while (!iend) begin @(negedge clk); n++; end
    chk_int("R10 timer restarts after test mode", n, IVL - 1);
    @(negedge clk);
    chk_vec("R11 load/step ignored in normal mode", held, pack(cv));
    tm = 1;
    xfer('0, got);
    chk_vec("R11 capture ignored in normal mode", got, '0);
    tm = 0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule